// File: doc/BRIEF.md
# Dual-Modulus Fractional Clock Divider

This block derives a slower event rate from a reference clock when the required ratio is not a whole number. It owns two integer moduli. One output period is counted with one modulus or the other, never a mix of both. The first modulus is used for a programmed number of consecutive output periods, then the second modulus for its own programmed number, and the pattern repeats. Over one full pattern the average ratio is (DIV1·REP1 + DIV2·REP2)/(REP1 + REP2). The instantaneous period jumps between the two moduli, and this jitter is accepted. Jitter is smallest when the two moduli are neighbouring integers on either side of the target ratio.

The output is a single-cycle enable pulse at the last input cycle of each divided period, for use as a clock enable in the reference domain. A flag shows which modulus governs the period in progress. Parameters can change at any time. They are captured into shadow registers only at the end of a full pattern, or during reset, so a pattern never mixes old and new settings.

Top module: `frac_clk_div`

## Requirements
- R1: While reset is high and on the first cycle after it, sel_two_o is 0 and both counters are cleared. With en_i held high from release, the first pulse arrives after exactly DIV1 cycles, even if reset interrupted a period.
- R2: Each output period lasts exactly the active modulus in enabled input cycles. The spacing between successive tick_o pulses equals that modulus.
- R3: The first modulus governs REP1 consecutive periods and the second governs REP2 consecutive periods. The two runs then alternate without end.
- R4: sel_two_o is 0 while the first modulus is active and 1 while the second is active. It changes only in the cycle after the pulse that closes the last period of a run.
- R5: tick_o is high for exactly one input cycle per period, and that cycle is the last cycle of the period.
- R6: A modulus value of 0 behaves as 1. A modulus of 1 gives a pulse on every enabled cycle.
- R7: A repetition value of 0 behaves as 1.
- R8: While en_i is low, neither counter advances, tick_o stays low and sel_two_o holds.
- R9: Values on the parameter inputs are taken into use only at the start of the next full pattern, or at reset. The pattern in progress finishes with the values it began with.
- R10: One full pattern spans DIV1·REP1 + DIV2·REP2 enabled input cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Advance enable |
| div_one_i | input | CNT_W | First modulus (0 acts as 1) |
| div_two_i | input | CNT_W | Second modulus (0 acts as 1) |
| rep_one_i | input | REP_W | Periods per run of the first modulus (0 acts as 1) |
| rep_two_i | input | REP_W | Periods per run of the second modulus (0 acts as 1) |
| tick_o | output | 1 | One-cycle pulse closing each divided period |
| sel_two_o | output | 1 | 0: first modulus active, 1: second active |

## Verification
The bench builds the block with its defaults: 8-bit moduli and 8-bit repetition counts. It drives the parameters at run time. This covers neighbouring moduli such as 3/4, the degenerate modulus 1 that pulses every cycle, and zero values for both moduli and repetitions. It also changes parameters partway through a pattern, which shows the deferred take-over. Each pulse spacing and flag value is compared with a sequence the bench expands from the parameter values, and the sum over a pattern is compared with the closed-form pattern length.

// File: rtl/dmd_pkg.sv
package dmd_pkg;
  typedef enum logic {
    PH_ONE = 1'b0,
    PH_TWO = 1'b1
  } dmd_phase_e;
endpackage

// File: rtl/dmd_param_shadow.sv
module dmd_param_shadow #(
  parameter int CNT_W = 8,
  parameter int REP_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [CNT_W-1:0] div_one_i,
  input  logic [CNT_W-1:0] div_two_i,
  input  logic [REP_W-1:0] rep_one_i,
  input  logic [REP_W-1:0] rep_two_i,
  output logic [CNT_W-1:0] div_one_q,
  output logic [CNT_W-1:0] div_two_q,
  output logic [REP_W-1:0] rep_one_q,
  output logic [REP_W-1:0] rep_two_q
);
  // Zero is mapped to one so every period and every run is non-empty
  function automatic logic [CNT_W-1:0] norm_div(input logic [CNT_W-1:0] v);
    return (v == '0) ? CNT_W'(1) : v;
  endfunction

  function automatic logic [REP_W-1:0] norm_rep(input logic [REP_W-1:0] v);
    return (v == '0) ? REP_W'(1) : v;
  endfunction

  always_ff @(posedge clk) begin
    if (rst || load_i) begin
      div_one_q <= norm_div(div_one_i);
      div_two_q <= norm_div(div_two_i);
      rep_one_q <= norm_rep(rep_one_i);
      rep_two_q <= norm_rep(rep_two_i);
    end
  end

  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> ($stable(div_one_q) && $stable(div_two_q) &&
                 $stable(rep_one_q) && $stable(rep_two_q)))
    else $error("shadow changed outside pattern boundary"); // R9

  AST_SHADOW_NONZERO: assert property (@(posedge clk) disable iff (rst)
    (div_one_q != '0) && (div_two_q != '0) && (rep_one_q != '0) && (rep_two_q != '0))
    else $error("zero value reached shadow"); // R6 R7
endmodule

// File: rtl/dmd_period_ctr.sv
module dmd_period_ctr #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             tick_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             at_end;

  function automatic logic is_last(input logic [CNT_W-1:0] c, input logic [CNT_W-1:0] lim);
    return c == (lim - CNT_W'(1));
  endfunction

  assign at_end = is_last(cnt_q, limit_i);
  assign tick_o = en_i && at_end;

  always_ff @(posedge clk) begin
    if (rst)           cnt_q <= '0;
    else if (tick_o)   cnt_q <= '0;
    else if (en_i)     cnt_q <= cnt_q + CNT_W'(1);
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q < limit_i)
    else $error("period counter past modulus"); // R2

  AST_CNT_FREEZE: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> $stable(cnt_q))
    else $error("period counter moved while disabled"); // R8
endmodule

// File: rtl/dmd_rep_seq.sv
module dmd_rep_seq
  import dmd_pkg::*;
#(
  parameter int REP_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic [REP_W-1:0] rep_one_i,
  input  logic [REP_W-1:0] rep_two_i,
  output dmd_phase_e       phase_o,
  output logic             wrap_o
);
  logic [REP_W-1:0] rcnt_q;
  logic [REP_W-1:0] cur_rep;
  logic             run_end;
  dmd_phase_e       phase_q;

  assign cur_rep = (phase_q == PH_TWO) ? rep_two_i : rep_one_i;
  assign run_end = tick_i && (rcnt_q == (cur_rep - REP_W'(1)));
  assign wrap_o  = run_end && (phase_q == PH_TWO);
  assign phase_o = phase_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rcnt_q  <= '0;
      phase_q <= PH_ONE;
    end else if (run_end) begin
      rcnt_q  <= '0;
      phase_q <= (phase_q == PH_ONE) ? PH_TWO : PH_ONE;
    end else if (tick_i) begin
      rcnt_q  <= rcnt_q + REP_W'(1);
    end
  end

  AST_REP_BOUND: assert property (@(posedge clk) disable iff (rst)
    rcnt_q < cur_rep)
    else $error("repetition counter past run length"); // R3

  AST_SEL_STEADY: assert property (@(posedge clk) disable iff (rst)
    !tick_i |=> $stable(phase_q))
    else $error("phase changed without a period boundary"); // R4

  AST_SEL_FLIP: assert property (@(posedge clk) disable iff (rst)
    run_end |=> (phase_q != $past(phase_q)))
    else $error("phase held after last period of run"); // R3
endmodule

// File: rtl/frac_clk_div.sv
module frac_clk_div
  import dmd_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int REP_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic [CNT_W-1:0] div_one_i,
  input  logic [CNT_W-1:0] div_two_i,
  input  logic [REP_W-1:0] rep_one_i,
  input  logic [REP_W-1:0] rep_two_i,
  output logic             tick_o,
  output logic             sel_two_o
);
  logic [CNT_W-1:0] div_one_q, div_two_q, active_div;
  logic [REP_W-1:0] rep_one_q, rep_two_q;
  logic             tick;
  logic             pattern_wrap;
  dmd_phase_e       phase;

  dmd_param_shadow #(.CNT_W(CNT_W), .REP_W(REP_W)) shadow_i (
    .clk(clk), .rst(rst), .load_i(pattern_wrap),
    .div_one_i(div_one_i), .div_two_i(div_two_i),
    .rep_one_i(rep_one_i), .rep_two_i(rep_two_i),
    .div_one_q(div_one_q), .div_two_q(div_two_q),
    .rep_one_q(rep_one_q), .rep_two_q(rep_two_q)
  );

  assign active_div = (phase == PH_TWO) ? div_two_q : div_one_q;

  dmd_period_ctr #(.CNT_W(CNT_W)) period_i (
    .clk(clk), .rst(rst), .en_i(en_i),
    .limit_i(active_div), .tick_o(tick)
  );

  dmd_rep_seq #(.REP_W(REP_W)) seq_i (
    .clk(clk), .rst(rst), .tick_i(tick),
    .rep_one_i(rep_one_q), .rep_two_i(rep_two_q),
    .phase_o(phase), .wrap_o(pattern_wrap)
  );

  assign tick_o    = tick;
  assign sel_two_o = (phase == PH_TWO);

  AST_TICK_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    !en_i |-> !tick_o)
    else $error("pulse while disabled"); // R8

  AST_UNIT_DIV_PULSE: assert property (@(posedge clk) disable iff (rst)
    (en_i && active_div == CNT_W'(1)) |-> tick_o)
    else $error("unit modulus missed a pulse"); // R6
endmodule

// File: tb/frac_clk_div_tb_top.sv
module frac_clk_div_tb_top;
  localparam int CNT_W = 8;
  localparam int REP_W = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             en_i = 1'b0;
  logic [CNT_W-1:0] div_one_i = '0;
  logic [CNT_W-1:0] div_two_i = '0;
  logic [REP_W-1:0] rep_one_i = '0;
  logic [REP_W-1:0] rep_two_i = '0;
  logic             tick_o;
  logic             sel_two_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  frac_clk_div #(.CNT_W(CNT_W), .REP_W(REP_W)) dut_i (
    .clk(clk), .rst(rst), .en_i(en_i),
    .div_one_i(div_one_i), .div_two_i(div_two_i),
    .rep_one_i(rep_one_i), .rep_two_i(rep_two_i),
    .tick_o(tick_o), .sel_two_o(sel_two_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_params(input int d1, input int d2, input int r1, input int r2);
    div_one_i = CNT_W'(d1);
    div_two_i = CNT_W'(d2);
    rep_one_i = REP_W'(r1);
    rep_two_i = REP_W'(r2);
  endtask

  // Reset for two cycles, leave at a falling edge with en_i high
  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; en_i = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0; en_i = 1'b1;
  endtask

  // Count cycles up to and including the next pulse; returns length and flag
  task automatic measure(output int len, output int sel);
    len = 0; sel = -1;
    for (int k = 0; k < 600; k++) begin
      #1;
      len++;
      if (tick_o) begin
        sel = int'(sel_two_o);
        @(negedge clk);
        return;
      end
      @(negedge clk);
    end
    len = -1;
  endtask

  task automatic expect_period(input int exp_len, input int exp_sel, input string tag);
    int len, sel;
    measure(len, sel);
    check(len == exp_len, {tag, " R2 R5 period"}, len, exp_len);
    check(sel == exp_sel, {tag, " R4 flag"}, sel, exp_sel);
  endtask

  task automatic t_reset_state();
    set_params(3, 4, 2, 1);
    @(negedge clk); rst = 1'b1; en_i = 1'b0;
    @(negedge clk); @(negedge clk); #1;
    check(sel_two_o == 1'b0, "R1 flag in reset", int'(sel_two_o), 0);
    check(tick_o == 1'b0, "R1 pulse in reset", int'(tick_o), 0);
    @(negedge clk); rst = 1'b0; en_i = 1'b1;
    expect_period(3, 0, "R1");
  endtask

  task automatic t_basic_pattern();
    int total = 0;
    int len, sel;
    set_params(3, 4, 2, 1);
    do_reset();
    for (int p = 0; p < 2; p++) begin
      expect_period(3, 0, "R3 run1");
      expect_period(3, 0, "R3 run1");
      expect_period(4, 1, "R3 run2");
    end
    for (int k = 0; k < 3; k++) begin
      measure(len, sel);
      total += len;
    end
    check(total == 3*2 + 4*1, "R10 pattern length", total, 10);
  endtask

  task automatic t_unit_div();
    set_params(1, 2, 1, 3);
    do_reset();
    for (int p = 0; p < 2; p++) begin
      expect_period(1, 0, "R6 unit");
      for (int k = 0; k < 3; k++) expect_period(2, 1, "R3 run2");
    end
  endtask

  task automatic t_zero_values();
    set_params(0, 5, 0, 2);
    do_reset();
    expect_period(1, 0, "R6 zero div");
    expect_period(5, 1, "R7 zero rep");
    expect_period(5, 1, "R7 zero rep");
    expect_period(1, 0, "R7 zero rep again");
  endtask

  task automatic t_enable_freeze();
    set_params(4, 4, 1, 1);
    do_reset();
    for (int k = 0; k < 2; k++) begin
      #1; check(tick_o == 1'b0, "R2 early pulse", int'(tick_o), 0);
      @(negedge clk);
    end
    en_i = 1'b0;
    for (int k = 0; k < 6; k++) begin
      #1;
      check(tick_o == 1'b0, "R8 pulse while disabled", int'(tick_o), 0);
      check(sel_two_o == 1'b0, "R8 flag while disabled", int'(sel_two_o), 0);
      @(negedge clk);
    end
    en_i = 1'b1;
    expect_period(2, 0, "R8 resume");
    expect_period(4, 1, "R8 next");
  endtask

  task automatic t_reset_mid_period();
    set_params(5, 6, 1, 1);
    do_reset();
    repeat (3) @(negedge clk);
    rst = 1'b1; en_i = 1'b0;
    @(negedge clk);
    rst = 1'b0; en_i = 1'b1;
    expect_period(5, 0, "R1 after mid reset");
  endtask

  task automatic t_deferred_update();
    set_params(3, 4, 2, 2);
    do_reset();
    expect_period(3, 0, "R9 old");
    set_params(6, 7, 1, 1);
    expect_period(3, 0, "R9 old kept");
    expect_period(4, 1, "R9 old kept");
    expect_period(4, 1, "R9 old kept");
    expect_period(6, 0, "R9 new");
    expect_period(7, 1, "R9 new");
    expect_period(6, 0, "R9 new");
  endtask

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset_state();
    t_basic_pattern();
    t_unit_div();
    t_zero_values();
    t_enable_freeze();
    t_reset_mid_period();
    t_deferred_update();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule